// File: doc/BRIEF.md
# Watchdog Timer with Guarded Reconfiguration

The block is a watchdog for a system controller. A counter advances on a slow tick derived from the system clock by a prescaler. Software must pulse `kick` often enough to keep the counter below the timeout chosen by a 4-bit period code. If it fails to, the block raises a one-cycle reset request. It also sets a flag that survives the system reset this request causes. Afterwards the watchdog keeps running at its shortest period.

The enable bit and the period code live in a control register that ordinary writes cannot change. A change needs a timed unlock first. One way is a control write with both the change-enable and enable bits set, followed within a short window by the write that carries the new value. The other way is to write a key to a separate key register and then make one qualifying control write. While the watchdog-reset flag is set, the watchdog cannot be switched off. A power-on reset leaves the watchdog off with the flag clear. A system reset keeps the enable bit and the flag, and drops the period back to code 0.

Top module: `wdog_guard`

## Requirements
- R1: After power-on reset the control readback is 0x00, the status readback is 0x00 and `rst_req` is low.
- R2: With the watchdog enabled, the timeout is TICK_DIV × BASE_TICKS × 2^code clock cycles, counted from the edge that sampled the last kick or accepted configuration write. Codes 10 to 15 behave as code 9.
- R3: A `kick` sampled high restarts the count, so kicks spaced closer than the timeout prevent any reset request.
- R4: On timeout `rst_req` is high for exactly one cycle, and the count then restarts. In the same step the flag in status bit 0 is set, the period code becomes 0 and the enable bit stays 1.
- R5: On the control register (address 0), bit 4 is enable, bits 2:0 are period code bits 2:0, and bit 5 is period code bit 3. A control write with bits 3 and 4 both set opens a window and alters neither enable nor period. A control write sampled 1 to 4 cycles later loads enable and period, and this closes the window.
- R6: A control write made with no window open, or 5 or more cycles after the opening write, leaves enable and period unchanged.
- R7: Opening the window and then writing 0x00 clears the enable bit. Once the enable bit is clear, no reset request is issued.
- R8: While status bit 0 is set, a loading write cannot clear the enable bit, though the period still loads. Writing status (address 1) with bit 0 set clears the flag, and a disable then takes effect.
- R9: Writing 0xD8 to the key register (address 2) opens a window in which one control write is accepted only if bits 3 and 4 are both set. A control write without them is ignored and closes the window. Any other key value opens nothing.
- R10: A system reset leaves the enable bit and status bit 0 unchanged and sets the period code to 0.
- R11: Control readback bit 3 reads 1 exactly while an unlock window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| rst_sys_n | input | 1 | System reset, active low, asynchronous assert |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 status, 2 key |
| wr_data | input | 8 | Write data |
| kick | input | 1 | Restart the watchdog count |
| ctrl_rd | output | 8 | Control readback: window, enable, period |
| stat_rd | output | 8 | Status readback: bit 0 watchdog-reset flag |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The bench probes the edges of the unlock window. It writes on the fourth cycle after the opening write, where the value must load, and on the fifth, where it must be ignored. A design whose window is one cycle off would load the late write or drop the valid one. It checks that the period bit placed apart from the low bits moves codes 8, 9 and an out-of-range code to the longest timeouts. A miswired decode shows up as a timeout that is too short. It also checks that a set flag blocks a disable, and that a system reset keeps the watchdog armed at code 0 with the flag still set. A design that cleared these would go quiet when it should fire.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_KEY  = 2'd2;

  localparam int CB_PLO = 0;  // period code bits 2:0 at 2:0
  localparam int CB_CEN = 3;  // change-enable / window open
  localparam int CB_EN  = 4;  // watchdog enable
  localparam int CB_PHI = 5;  // period code bit 3, kept apart from the low bits
  localparam int SB_WDRF = 0; // watchdog-reset flag

  localparam logic [REG_W-1:0] UNLOCK_KEY = 8'hD8;
  localparam logic [3:0] MAX_CODE = 4'd9;

  typedef enum logic {WIN_SEQ = 1'b0, WIN_KEY = 1'b1} wd_win_e;

  function automatic logic [3:0] clamp_code(input logic [3:0] c);
    return (c > MAX_CODE) ? MAX_CODE : c;
  endfunction

  function automatic logic [3:0] pick_code(input logic [REG_W-1:0] d);
    return {d[CB_PHI], d[CB_PLO +: 3]};
  endfunction
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    tick  = 1'b0;
    pre_d = pre_q;
    if (restart || !run) begin
      pre_d = '0;
    end else if (pre_q == LAST) begin
      pre_d = '0;
      tick  = 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int TICK_DIV   = 128,
  parameter int BASE_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] code,
  input  logic       restart,
  output logic       timeout,
  output logic       rst_req
);
  localparam int MAX_TICKS = BASE_TICKS << MAX_CODE;
  localparam int CW = $clog2(MAX_TICKS + 1);

  logic          tick;
  logic [CW-1:0] limit;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;
  logic          req_q;

  wdog_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en),
    .restart (restart),
    .tick    (tick)
  );

  assign limit = CW'(BASE_TICKS) << clamp_code(code);

  always_comb begin
    timeout = 1'b0;
    cnt_d   = cnt_q;
    cnt_ce  = 1'b0;
    if (restart || !en) begin
      cnt_ce = 1'b1;
      cnt_d  = '0;
    end else if (tick) begin
      cnt_ce = 1'b1;
      if (cnt_q == limit - 1'b1) begin
        timeout = 1'b1;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= timeout;
  end

  assign rst_req = req_q;
endmodule

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
#(
  parameter int WIN_CYCLES = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             any_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             timeout,
  output logic             en,
  output logic [3:0]       code,
  output logic             win_open,
  output logic             flag,
  output logic             load
);
  localparam int WW = $clog2(WIN_CYCLES + 1);
  localparam logic [WW-1:0] WIN_FULL = WW'(WIN_CYCLES);

  logic          en_q, en_d;
  logic          flag_q, flag_d;
  logic [3:0]    code_q, code_d;
  logic [WW-1:0] win_q, win_d;
  wd_win_e       kind_q, kind_d;

  logic is_ctrl, is_stat, is_key, cen_en, open_q;

  assign is_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign is_stat = wr_en && (wr_addr == ADDR_STAT);
  assign is_key  = wr_en && (wr_addr == ADDR_KEY);
  assign cen_en  = wr_data[CB_CEN] && wr_data[CB_EN];
  assign open_q  = (win_q != '0);

  always_comb begin
    en_d   = en_q;
    flag_d = flag_q;
    code_d = code_q;
    kind_d = kind_q;
    win_d  = open_q ? win_q - 1'b1 : win_q;
    load   = 1'b0;

    if (is_key) begin
      if (wr_data == UNLOCK_KEY) begin
        win_d  = WIN_FULL;
        kind_d = WIN_KEY;
      end
    end else if (is_ctrl) begin
      if (open_q && ((kind_q == WIN_SEQ) || cen_en)) begin
        load   = 1'b1;
        code_d = pick_code(wr_data);
        en_d   = wr_data[CB_EN] || (flag_q && en_q);
        win_d  = '0;
      end else if (open_q) begin
        win_d = '0;
      end else if (cen_en) begin
        win_d  = WIN_FULL;
        kind_d = WIN_SEQ;
      end
    end

    if (is_stat && wr_data[SB_WDRF]) flag_d = 1'b0;

    if (timeout) begin
      flag_d = 1'b1;
      code_d = '0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge any_n) begin
    if (!any_n) begin
      code_q <= '0;
      win_q  <= '0;
      kind_q <= WIN_SEQ;
    end else begin
      code_q <= code_d;
      win_q  <= win_d;
      kind_q <= kind_d;
    end
  end

  assign en       = en_q;
  assign code     = code_q;
  assign win_open = open_q;
  assign flag     = flag_q;
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int TICK_DIV    = 128,
  parameter int BASE_TICKS  = 16,
  parameter int WIN_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_por_n,
  input  logic             rst_sys_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             kick,
  output logic [REG_W-1:0] ctrl_rd,
  output logic [REG_W-1:0] stat_rd,
  output logic             rst_req
);
  localparam int NRST = 2;

  logic [NRST-1:0] raw_n, sync_n;
  logic            por_s_n, any_s_n;
  logic            en, win_open, flag, load, timeout;
  logic [3:0]      code;

  assign raw_n = {rst_por_n & rst_sys_n, rst_por_n};

  for (genvar g = 0; g < NRST; g++) begin : g_rsync
    wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (raw_n[g]),
      .srst_n (sync_n[g])
    );
  end

  assign por_s_n = sync_n[0];
  assign any_s_n = sync_n[1];

  wdog_unlock #(.WIN_CYCLES(WIN_CYCLES)) u_cfg (
    .clk      (clk),
    .por_n    (por_s_n),
    .any_n    (any_s_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .timeout  (timeout),
    .en       (en),
    .code     (code),
    .win_open (win_open),
    .flag     (flag),
    .load     (load)
  );

  wdog_count #(.TICK_DIV(TICK_DIV), .BASE_TICKS(BASE_TICKS)) u_cnt (
    .clk     (clk),
    .rst_n   (any_s_n),
    .en      (en),
    .code    (code),
    .restart (kick || load),
    .timeout (timeout),
    .rst_req (rst_req)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CB_PLO +: 3] = code[2:0];
    ctrl_rd[CB_CEN]      = win_open;
    ctrl_rd[CB_EN]       = en;
    ctrl_rd[CB_PHI]      = code[3];
    stat_rd = '0;
    stat_rd[SB_WDRF]     = flag;
  end
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk (
  input logic       clk,
  input logic       por_n,
  input logic       any_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [5:0] ctrl_bits,
  input logic       wdrf,
  input logic       rst_req,
  input logic       timeout
);
  // R4: the request lasts one cycle
  assert_req_single_R4: assert property (@(posedge clk) disable iff (!any_n)
    rst_req |=> !rst_req);

  // R4: a request comes with flag set, enable kept and period code 0
  assert_timeout_state_R4: assert property (@(posedge clk) disable iff (!any_n)
    rst_req |-> (wdrf && ctrl_bits[4] && !ctrl_bits[5] && (ctrl_bits[2:0] == 3'd0)));

  // R8: a set flag keeps the watchdog enabled
  assert_hold_enable_R8: assert property (@(posedge clk) disable iff (!por_n)
    (wdrf && ctrl_bits[4]) |=> ctrl_bits[4]);

  // R6: a control write with no window open leaves enable and period alone
  assert_locked_R6: assert property (@(posedge clk) disable iff (!any_n)
    (wr_en && (wr_addr == 2'd0) && !ctrl_bits[3] && !timeout)
      |=> ($stable(ctrl_bits[5:4]) && $stable(ctrl_bits[2:0])));

  // R7: no request while the watchdog has been off
  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!any_n)
    (!ctrl_bits[4] && $past(!ctrl_bits[4])) |-> !rst_req);
endmodule

bind wdog_guard wdog_guard_chk u_chk (
  .clk       (clk),
  .por_n     (por_s_n),
  .any_n     (any_s_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .ctrl_bits (ctrl_rd[5:0]),
  .wdrf      (stat_rd[0]),
  .rst_req   (rst_req),
  .timeout   (timeout)
);

// File: tb/sim_wdog_guard.sv
module sim_wdog_guard;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DIV  = 2;
  localparam int BASE = 4;
  localparam int WIN  = 4;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_KEY  = 2'd2;

  logic       clk = 1'b0;
  logic       rst_por_n, rst_sys_n, wr_en, kick;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] ctrl_rd, stat_rd;
  logic       rst_req;

  int     n_cmp = 0;
  int     n_bad = 0;
  longint cyc   = 0;
  longint mark  = 0;
  int     exp_q[$];
  string  tag_q[$];

  always #2.5 clk = ~clk;

  wdog_guard #(.TICK_DIV(DIV), .BASE_TICKS(BASE), .WIN_CYCLES(WIN)) u0 (
    .clk(clk), .rst_por_n(rst_por_n), .rst_sys_n(rst_sys_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .kick(kick),
    .ctrl_rd(ctrl_rd), .stat_rd(stat_rd), .rst_req(rst_req)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: every reset request is matched against the next expected timeout
  always @(negedge clk) begin
    if (rst_por_n && rst_req) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R4: unexpected reset request at cycle %0d, actual 1 expected 0", cyc);
      end else begin
        string t;
        int    e;
        int    got;
        t   = tag_q.pop_front();
        e   = exp_q.pop_front();
        got = int'(cyc - mark);
        n_cmp++;
        if (got != e) begin
          n_bad++;
          $display("FAIL %s: timeout after %0d cycles, expected %0d", t, got, e);
        end
      end
      mark = cyc;
    end
  end

  function automatic logic [7:0] cbyte(input int c);
    logic [3:0] k;
    k = 4'(c);
    return {2'b00, k[3], 1'b1, 1'b0, k[2:0]};
  endfunction

  function automatic int exp_cycles(input int c);
    int k;
    k = (c > 9) ? 9 : c;
    return DIV * BASE * (1 << k);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_to(input string req, input int c);
    tag_q.push_back(req);
    exp_q.push_back(exp_cycles(c));
  endtask

  // all driver tasks are entered at a falling edge and return at one
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic do_kick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    mark = cyc;
  endtask

  task automatic load(input int c);
    wr(A_CTRL, 8'h18);
    wr(A_CTRL, cbyte(c));
    mark = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(A_STAT, 8'h01);
    wr(A_CTRL, 8'h18);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_por_n = 1'b0; rst_sys_n = 1'b1;
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'h00; kick = 1'b0;
    idle(4);
    rst_por_n = 1'b1;
    idle(3);
    check("R1 control", ctrl_rd, 8'h00);
    check("R1 status", stat_rd, 8'h00);
    check("R1 request", rst_req, 1'b0);

    // R6: plain write with nothing unlocked
    wr(A_CTRL, 8'h15);
    check("R6 locked write", ctrl_rd, 8'h00);
    idle(40);

    // R5/R11/R4: sequence unlock, timeout, forced fastest period
    wr(A_CTRL, 8'h18);
    check("R11 window flag", ctrl_rd, 8'h08);
    wr(A_CTRL, 8'h12);
    mark = cyc;
    check("R5 load code 2", ctrl_rd, 8'h12);
    push_to("R2 code 2", 2);
    push_to("R4 fastest period after timeout", 0);
    while (exp_q.size() == 2) @(negedge clk);
    check("R4 flag set", stat_rd, 8'h01);
    check("R4 enabled code 0", ctrl_rd, 8'h10);
    drain();

    // R8: disable blocked by flag, period still loads (code 9)
    wr(A_CTRL, 8'h18);
    wr(A_CTRL, 8'h21);
    check("R8 disable blocked", ctrl_rd, 8'h31);
    wr(A_STAT, 8'h01);
    check("R8 flag cleared", stat_rd, 8'h00);
    wr(A_CTRL, 8'h18);
    wr(A_CTRL, 8'h00);
    check("R7 disabled", ctrl_rd, 8'h00);
    idle(200);
    check("R7 no request", rst_req, 1'b0);

    // R3: kicks hold off the timeout
    load(1);
    for (int i = 0; i < 6; i++) begin
      idle(10);
      do_kick();
    end
    push_to("R3 timeout from last kick", 1);
    drain();
    quiesce();
    check("R3 quiesced", ctrl_rd, 8'h00);

    // R2/R5: period decode sweep, including code bit 3 in bit 5
    for (int c = 0; c <= 12; c++) begin
      if (c == 10 || c == 11) continue;
      load(c);
      check($sformatf("R5 readback code %0d", c), ctrl_rd, cbyte(c));
      push_to($sformatf("R2 code %0d", c), c);
      drain();
      quiesce();
    end
    check("R2 sweep quiesced", stat_rd, 8'h00);

    // R5/R6/R11: window edges
    load(3);
    wr(A_CTRL, 8'h18);
    check("R5 opening write keeps fields", ctrl_rd, 8'h1B);
    idle(3);
    wr(A_CTRL, 8'h15);
    mark = cyc;
    check("R5 write on last window cycle", ctrl_rd, 8'h15);
    quiesce();
    check("R7 disabled again", ctrl_rd, 8'h00);
    wr(A_CTRL, 8'h18);
    idle(WIN);
    check("R11 window expired", ctrl_rd, 8'h00);
    wr(A_CTRL, 8'h12);
    check("R6 late write", ctrl_rd, 8'h00);

    // R9: key path
    wr(A_KEY, 8'hD7);
    wr(A_CTRL, 8'h14);
    check("R9 wrong key", ctrl_rd, 8'h00);
    wr(A_KEY, 8'hD8);
    check("R9 key opens window", ctrl_rd, 8'h08);
    wr(A_CTRL, 8'h14);
    check("R9 write lacking change bits", ctrl_rd, 8'h00);
    wr(A_KEY, 8'hD8);
    wr(A_CTRL, 8'h1C);
    mark = cyc;
    check("R9 key load code 4", ctrl_rd, 8'h14);
    push_to("R9 code 4 via key", 4);
    drain();
    quiesce();

    // R10: system reset keeps the watchdog armed
    load(5);
    idle(20);
    rst_sys_n = 1'b0;
    idle(3);
    check("R10 enabled code 0", ctrl_rd, 8'h10);
    rst_sys_n = 1'b1;
    idle(3);
    do_kick();
    push_to("R10 fastest period after system reset", 0);
    drain();
    check("R10 flag after timeout", stat_rd, 8'h01);
    rst_sys_n = 1'b0;
    idle(2);
    check("R10 flag kept", stat_rd, 8'h01);
    check("R10 still enabled", ctrl_rd, 8'h10);
    rst_sys_n = 1'b1;
    idle(2);
    quiesce();
    check("R10 quiesced", ctrl_rd, 8'h00);

    // R1: power-on reset disarms
    load(2);
    rst_por_n = 1'b0;
    idle(2);
    rst_por_n = 1'b1;
    idle(3);
    check("R1 after power-on control", ctrl_rd, 8'h00);
    check("R1 after power-on status", stat_rd, 8'h00);
    idle(100);
    check("R1 no request", rst_req, 1'b0);

    summary();
    $finish;
  end
endmodule